// File: doc/BRIEF.md
# Multi-Channel Event Record Builder

The block collects fixed-length event fragments arriving on several independent input channels and, once a trigger accept is pending and every enabled channel holds a full fragment, emits one record on a word-wide output stream. A record opens with two control-flagged header words, continues with one fragment from each enabled channel in ascending channel order, and closes with a control-flagged trailer that carries a CRC-16 over everything before it. The record length depends only on the enable mask and the fragment length, because no words are ever suppressed.

Each channel has its own receiver and FIFO. The receiver accepts a fragment only if its first word carries the expected tag and the FIFO has room for the whole fragment. It counts the fragments it has stored, and that count is compared with the number of trigger accepts. Each FIFO reports empty, half, three-quarter and full levels. A summary warning is raised while any enabled channel reaches three quarters.

Top module: `evrec_builder`

## Requirements
- R1: A word that arrives while its channel is outside a fragment opens a fragment only if bits [W-1:W-4] equal 4'hA. A fragment that does not open this way leaves no word in the FIFO and does not change the stored-fragment count. The EVW-1 words that follow an opening word belong to that fragment.
- R2: For each channel, with N words stored, fifo_empty = (N==0), fifo_half = (N>=DEPTH/2), fifo_warn75 = (N>=3*DEPTH/4) and fifo_full = (N==DEPTH).
- R3: A fragment is stored only if the FIFO holds at most DEPTH-EVW words when its tagged first word arrives. If not, the whole fragment is dropped and is not counted.
- R4: cnt_err[c] = act_mask[c] AND (the number of fragments stored on channel c, mod 2^CW, differs from the number of trig pulses, mod 2^CW).
- R5: A record starts only when more trig pulses have been seen than records sent, and every channel enabled in act_mask holds at least one complete fragment.
- R6: The words of a record are sent on consecutive cycles with out_valid high. Word 0 is the record number, zero-extended: 0 for the first record after reset and +1 for each later record. Word 1 is the enable mask, zero-extended. Both have out_ctrl=1. Then come EVW words from each enabled channel, lowest channel first, each the oldest stored fragment of that channel, with out_ctrl=0. The last word is the trailer, with out_ctrl=1.
- R7: The trailer holds a CRC-16 over the header and data words, in order, each fed MSB first. The generator polynomial is 0x1021, the seed is 0xFFFF, and there is no reflection and no final XOR.
- R8: A channel that is disabled when a record starts gives no words to that record, and its stored words stay in its FIFO for later records.
- R9: warn is high exactly while some channel has both act_mask[c] and fifo_warn75[c] high.
- R10: A record is 3+EVW*popcount(mask) words long. At least one idle cycle separates two records.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig | input | 1 | Trigger accept pulse, one per cycle high |
| act_mask | input | NCH | Channel enables, sampled at record start |
| ch_valid | input | NCH | Per-channel input word strobe |
| ch_data | input | NCH*W | Per-channel input words, channel c at [c*W +: W] |
| out_valid | output | 1 | Output word valid |
| out_ctrl | output | 1 | Marks header and trailer words |
| out_data | output | W | Output word |
| fifo_empty | output | NCH | FIFO holds no word |
| fifo_half | output | NCH | FIFO at least half full |
| fifo_warn75 | output | NCH | FIFO at least three-quarter full |
| fifo_full | output | NCH | FIFO full |
| cnt_err | output | NCH | Stored-fragment count differs from trigger count |
| warn | output | 1 | Some enabled channel is at three quarters |

## Verification
A channel FIFO can be written by its receiver and read by the record sender in the same cycle. The stored-fragment count can also rise and fall in one edge. The bench provokes this by sending new fragments, and new trigger pulses, every twenty cycles while earlier records are still draining. It then judges every drained record word by word against a model queue and checks the FIFO levels once all is quiet. A second overlap is a trailer ending in the same cycle that a new trigger arrives. The bench covers it through the same stream and requires one record per trigger, with record numbers counting up without a gap.

// File: rtl/evrec_builder.sv
module evrec_builder #(
  parameter int NCH   = 4,
  parameter int W     = 16,
  parameter int DEPTH = 16,
  parameter int EVW   = 4,
  parameter int CW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic [NCH-1:0]   act_mask,
  input  logic [NCH-1:0]   ch_valid,
  input  logic [NCH*W-1:0] ch_data,
  output logic             out_valid,
  output logic             out_ctrl,
  output logic [W-1:0]     out_data,
  output logic [NCH-1:0]   fifo_empty,
  output logic [NCH-1:0]   fifo_half,
  output logic [NCH-1:0]   fifo_warn75,
  output logic [NCH-1:0]   fifo_full,
  output logic [NCH-1:0]   cnt_err,
  output logic             warn
);
  localparam int AW  = $clog2(DEPTH);
  localparam int NW  = $clog2(DEPTH + 1);
  localparam int CI  = $clog2(NCH);
  localparam int CIW = CI + 1;
  localparam int EW  = $clog2(EVW + 1);
  localparam logic [3:0] TAG = 4'hA;

  typedef enum logic [1:0] {S_IDLE, S_HDR, S_DATA, S_TRL} st_t;

  st_t            st;
  logic           hidx;
  logic [EW-1:0]  wcnt;
  logic [CIW-1:0] cur;
  logic [NCH-1:0] act_q;
  logic [15:0]    crc;
  logic [CW-1:0]  trg_cnt, rec_no;

  logic [NCH-1:0] push, pop, pop_last, rx_done, avail_nz;
  logic [W-1:0]   head [NCH];
  logic [CW-1:0]  rxc  [NCH];
  logic           pending, ready_all;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [W-1:0] d);
    logic [15:0] r;
    r = c;
    for (int i = W - 1; i >= 0; i--)
      r = {r[14:0], 1'b0} ^ ((r[15] ^ d[i]) ? 16'h1021 : 16'h0000);
    return r;
  endfunction

  function automatic logic [CIW-1:0] next_act(input logic [NCH-1:0] m, input int from);
    logic [CIW-1:0] r;
    r = CIW'(NCH);
    for (int i = NCH - 1; i >= 0; i--)
      if (m[i] && i > from) r = CIW'(i);
    return r;
  endfunction

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [NW-1:0] cnt, avail;
    logic [EW-1:0] rwc;
    logic          in_evt;
    logic [CW-1:0] nrx;
    wire  [W-1:0]  din   = ch_data[c*W +: W];
    wire           admit = ch_valid[c] & ~in_evt & (din[W-1 -: 4] == TAG)
                           & (cnt <= NW'(DEPTH - EVW));

    assign push[c]     = ch_valid[c] & (in_evt | admit);
    assign rx_done[c]  = push[c] & (in_evt ? (rwc == EW'(EVW - 1)) : (EVW == 1));
    assign pop[c]      = (st == S_DATA) && (cur == CIW'(c));
    assign pop_last[c] = pop[c] && (wcnt == EW'(EVW - 1));
    assign avail_nz[c] = (avail != '0);
    assign head[c]     = mem[rptr];
    assign rxc[c]      = nrx;

    assign fifo_empty[c]  = (cnt == '0);
    assign fifo_half[c]   = (cnt >= NW'(DEPTH / 2));
    assign fifo_warn75[c] = (cnt >= NW'((3 * DEPTH) / 4));
    assign fifo_full[c]   = (cnt == NW'(DEPTH));
    assign cnt_err[c]     = act_mask[c] && (nrx != trg_cnt);

    always_ff @(posedge clk) begin
      if (push[c]) mem[wptr] <= din;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wptr   <= '0;
        rptr   <= '0;
        cnt    <= '0;
        avail  <= '0;
        rwc    <= '0;
        in_evt <= 1'b0;
        nrx    <= '0;
      end else begin
        if (push[c]) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
        if (pop[c])  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
        cnt   <= cnt + NW'(push[c]) - NW'(pop[c]);
        avail <= avail + NW'(rx_done[c]) - NW'(pop_last[c]);
        nrx   <= nrx + CW'(rx_done[c]);
        if (rx_done[c]) begin
          in_evt <= 1'b0;
          rwc    <= '0;
        end else if (push[c]) begin
          in_evt <= 1'b1;
          rwc    <= rwc + 1'b1;
        end
      end
    end

    assert_flag_nest_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_full[c] |-> fifo_warn75[c]) and (fifo_warn75[c] |-> fifo_half[c])
      and !(fifo_full[c] && fifo_empty[c]));
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_full[c] |-> !push[c]);
    assert_pop_has_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pop[c] |-> !fifo_empty[c]);
    assert_inactive_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (st != S_IDLE && !act_q[c]) |-> !pop[c]);
  end

  assign pending   = (trg_cnt != rec_no);
  assign ready_all = &(~act_mask | avail_nz);
  assign warn      = |(act_mask & fifo_warn75);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      hidx      <= 1'b0;
      wcnt      <= '0;
      cur       <= '0;
      act_q     <= '0;
      crc       <= 16'hFFFF;
      trg_cnt   <= '0;
      rec_no    <= '0;
      out_valid <= 1'b0;
      out_ctrl  <= 1'b0;
      out_data  <= '0;
    end else begin
      trg_cnt <= trg_cnt + CW'(trig);
      case (st)
        S_IDLE: begin
          out_valid <= 1'b0;
          out_ctrl  <= 1'b0;
          if (pending && ready_all) begin
            act_q <= act_mask;
            crc   <= 16'hFFFF;
            hidx  <= 1'b0;
            st    <= S_HDR;
          end
        end
        S_HDR: begin
          out_valid <= 1'b1;
          out_ctrl  <= 1'b1;
          out_data  <= hidx ? W'(act_q) : W'(rec_no);
          crc       <= crc_step(crc, hidx ? W'(act_q) : W'(rec_no));
          hidx      <= 1'b1;
          if (hidx) begin
            wcnt <= '0;
            cur  <= next_act(act_q, -1);
            st   <= (next_act(act_q, -1) == CIW'(NCH)) ? S_TRL : S_DATA;
          end
        end
        S_DATA: begin
          out_valid <= 1'b1;
          out_ctrl  <= 1'b0;
          out_data  <= head[cur[CI-1:0]];
          crc       <= crc_step(crc, head[cur[CI-1:0]]);
          wcnt      <= wcnt + 1'b1;
          if (wcnt == EW'(EVW - 1)) begin
            wcnt <= '0;
            cur  <= next_act(act_q, int'(cur));
            if (next_act(act_q, int'(cur)) == CIW'(NCH)) st <= S_TRL;
          end
        end
        S_TRL: begin
          out_valid <= 1'b1;
          out_ctrl  <= 1'b1;
          out_data  <= W'(crc);
          rec_no    <= rec_no + 1'b1;
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_start_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HDR && $past(st) == S_IDLE) |-> ($past(pending) && $past(ready_all)));
  assert_opens_with_number_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (out_ctrl && out_data == W'(rec_no)));
  assert_data_not_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ctrl) |=> out_valid);
  assert_gap_after_record_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TRL) |=> (st == S_IDLE));
endmodule

// File: tb/test_evrec_builder.sv
module test_evrec_builder;
  localparam int NCH = 4, W = 16, DEPTH = 16, EVW = 4, CW = 8;

  logic clk = 1'b0, rst_n = 1'b0, trig = 1'b0;
  logic [NCH-1:0] act_mask = '0, ch_valid = '0;
  logic [NCH*W-1:0] ch_data = '0;
  logic out_valid, out_ctrl, warn;
  logic [W-1:0] out_data;
  logic [NCH-1:0] fifo_empty, fifo_half, fifo_warn75, fifo_full, cnt_err;

  evrec_builder #(.NCH(NCH), .W(W), .DEPTH(DEPTH), .EVW(EVW), .CW(CW)) i_evrec_builder (
    .clk(clk), .rst_n(rst_n), .trig(trig), .act_mask(act_mask), .ch_valid(ch_valid),
    .ch_data(ch_data), .out_valid(out_valid), .out_ctrl(out_ctrl), .out_data(out_data),
    .fifo_empty(fifo_empty), .fifo_half(fifo_half), .fifo_warn75(fifo_warn75),
    .fifo_full(fifo_full), .cnt_err(cnt_err), .warn(warn));

  always #5 clk = ~clk;

  int vectors = 0, errors = 0;
  logic [15:0] mbuf [NCH][256];
  int mh [NCH], mt [NCH], rxm [NCH];
  int trig_m = 0, rec_exp = 0, rec_seen = 0, seed = 0;
  logic [15:0] rbuf [64];
  int rlen = 0, nctl = 0;
  bit done = 0;

  function automatic logic [15:0] crc16(input logic [15:0] c, input logic [15:0] d);
    logic [15:0] r = c;
    for (int i = 15; i >= 0; i--) begin
      logic fb = r[15] ^ d[i];
      r = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic judge_record();
    logic [15:0] e [64];
    int n = 0;
    logic [15:0] c = 16'hFFFF;
    e[n++] = 16'(rec_exp % 256);
    e[n++] = 16'(act_mask);
    for (int ch = 0; ch < NCH; ch++)
      if (act_mask[ch])
        for (int k = 0; k < EVW; k++) begin
          e[n++] = mbuf[ch][mh[ch] % 256];
          mh[ch]++;
        end
    for (int k = 0; k < n; k++) c = crc16(c, e[k]);
    e[n++] = c;
    chk(rlen == n, "R10 record length", rlen, n);
    for (int k = 0; k < n && k < rlen; k++)
      if (rbuf[k] !== e[k]) begin
        chk(0, (k < 2) ? "R6 header word" : (k == n - 1) ? "R7 trailer crc" : "R6 R8 data word",
            int'(rbuf[k]), int'(e[k]));
        break;
      end
    vectors++;
    rec_exp++;
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (rlen < 64) rbuf[rlen] = out_data;
      rlen++;
      if (out_ctrl) nctl++;
      if (out_ctrl && nctl == 3) begin
        judge_record();
        rec_seen++;
        rlen = 0;
        nctl = 0;
      end
    end
  end

  task automatic check_state(input string tag);
    logic [NCH-1:0] e_em, e_h, e_w, e_f, e_err;
    for (int c = 0; c < NCH; c++) begin
      int sz = mt[c] - mh[c];
      e_em[c] = (sz == 0); e_h[c] = (sz >= DEPTH / 2);
      e_w[c]  = (sz >= (3 * DEPTH) / 4); e_f[c] = (sz == DEPTH);
      e_err[c] = act_mask[c] && ((rxm[c] % 256) != (trig_m % 256));
    end
    chk(fifo_empty == e_em, {"R1 R2 empty ", tag}, fifo_empty, e_em);
    chk(fifo_half == e_h, {"R2 half ", tag}, fifo_half, e_h);
    chk(fifo_warn75 == e_w, {"R2 warn75 ", tag}, fifo_warn75, e_w);
    chk(fifo_full == e_f, {"R2 R3 full ", tag}, fifo_full, e_f);
    chk(cnt_err == e_err, {"R4 count mismatch ", tag}, cnt_err, e_err);
    chk(warn == |(act_mask & e_w), {"R9 warn ", tag}, warn, |(act_mask & e_w));
  endtask

  task automatic send_ev(input logic [NCH-1:0] chs, input bit good, input bit with_trig);
    seed++;
    for (int c = 0; c < NCH; c++)
      if (chs[c] && good && (mt[c] - mh[c]) <= DEPTH - EVW) begin
        for (int k = 0; k < EVW; k++)
          mbuf[c][(mt[c] + k) % 256] = (k == 0) ? {4'hA, 12'(seed * 5 + c)}
                                                : {4'(k), 12'(seed * 7 + c * 13 + k)};
        mt[c] += EVW;
        rxm[c]++;
      end
    for (int k = 0; k < EVW; k++) begin
      @(negedge clk);
      trig = with_trig && k == 0;
      if (trig) trig_m++;
      ch_valid = chs;
      for (int c = 0; c < NCH; c++)
        ch_data[c*W +: W] = (k == 0) ? (good ? {4'hA, 12'(seed * 5 + c)} : {4'h3, 12'(seed)})
                                     : {4'(k), 12'(seed * 7 + c * 13 + k)};
    end
    @(negedge clk);
    ch_valid = '0;
    trig = 1'b0;
  endtask

  task automatic pulse_trig();
    @(negedge clk);
    trig = 1'b1;
    trig_m++;
    @(negedge clk);
    trig = 1'b0;
  endtask

  task automatic wait_rec(input int n, input string tag);
    int t = 0;
    while (rec_seen < n && t < 3000) begin
      @(negedge clk);
      t++;
    end
    if (rec_seen < n) chk(0, {"R5 record missing ", tag}, rec_seen, n);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (2000 * 100) @(posedge clk);
    if (!done) begin
      errors++;
      vectors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin mh[c] = 0; mt[c] = 0; rxm[c] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    act_mask = 4'hF;
    @(negedge clk);
    chk(out_valid == 1'b0, "R6 reset idle", out_valid, 0);
    check_state("after reset");

    // R1: untagged fragment on channel 0 is discarded
    send_ev(4'h1, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    check_state("bad tag");

    // R5: trigger with empty FIFOs must not start a record
    pulse_trig();
    repeat (12) @(negedge clk);
    chk(out_valid == 1'b0 && rec_seen == 0, "R5 no fragments", out_valid, 0);

    // simultaneous push and pop: fragments keep arriving while records drain
    for (int k = 0; k < 6; k++) begin
      send_ev(4'hF, 1'b1, k > 0);
      repeat (15) @(negedge clk);
    end
    wait_rec(6, "overlap");
    check_state("overlap");

    // mask sweep: inactive channels accumulate, overflow, then drain later
    for (int m = 0; m < 16; m++) begin
      act_mask = 4'(m);
      send_ev(4'hF, 1'b1, 1'b0);
      repeat (4) @(negedge clk);
      chk(out_valid == 1'b0, "R5 no pending trigger", out_valid, 0);
      pulse_trig();
      wait_rec(rec_seen + 1, "sweep");
      check_state("sweep");
    end

    // drain leftovers with all channels enabled where possible
    for (int k = 0; k < 4; k++) begin
      act_mask = '0;
      for (int c = 0; c < NCH; c++) if (mt[c] - mh[c] >= EVW) act_mask[c] = 1'b1;
      pulse_trig();
      wait_rec(rec_seen + 1, "drain");
      check_state("drain");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule